// File: doc/BRIEF.md
# RMII to MII Receive Converter

This block sits between a reduced-pin Ethernet PHY and a MAC that expects a 4-bit receive bus. It runs entirely from the 50 MHz reference clock. It takes the PHY's 2-bit receive stream, its combined carrier/data-valid line and an optional receive-error line. It produces a divided receive clock for the MAC, together with a nibble-wide data bus, a data-valid flag and an error flag. All of these outputs change only on the rising edge of that clock, so the MAC can sample them on the falling edge.

At the start of a frame, the zero dibits that may precede the preamble are discarded. The first nonzero dibit fixes the pairing of dibits into nibbles. The carrier line may toggle at nibble rate after the carrier is lost, while the PHY still holds buffered data. The block keeps forwarding data through this toggling. A frame closes only when the carrier line is low on both dibits of one nibble. A static input selects 100 Mbps operation, with one sample per reference cycle, or 10 Mbps operation, with one sample every tenth cycle.

Top module: `rmii_rx_to_mii`

## Requirements
- R1: While rst_ni is low, mii_rx_clk_o, mii_rx_dv_o, mii_rxd_o and mii_rx_er_o are all 0.
- R2: Dibits equal to 00 that arrive with crs_dv_i high before the first nonzero dibit produce no nibble. The first nonzero dibit is the low half of the first nibble.
- R3: Each nibble carries the earlier dibit in bits [1:0] and the later dibit in bits [3:2]. A preamble of 31 dibits of 01 followed by one 11 dibit gives fifteen nibbles of 0x5 and then one nibble of 0xD.
- R4: From its first nibble to its last, a frame keeps mii_rx_dv_o high, with one nibble per mii_rx_clk_o period and no gap.
- R5: A nibble whose first dibit has crs_dv_i low and whose second dibit has it high is still forwarded. The frame ends without a nibble when crs_dv_i is low on both dibits of one nibble.
- R6: Whenever mii_rx_dv_o is 0, mii_rxd_o is 0000 and mii_rx_er_o is 0.
- R7: mii_rx_clk_o has a period of 2 reference cycles at 100 Mbps and 20 at 10 Mbps. mii_rx_dv_o, mii_rxd_o and mii_rx_er_o change only on the edge where mii_rx_clk_o rises.
- R8: With rate_10_i = 1, the inputs are sampled only on the first cycle after reset release and every tenth cycle after it. Values present in the other nine cycles have no effect.
- R9: If crs_dv_i is low on the second dibit of the first nibble (right after the first nonzero dibit), that partial nibble is dropped, no frame is output and the receiver returns to idle.
- R10: rx_er_i high on either dibit of a nibble inside a frame sets mii_rx_er_o for that nibble only.
- R11: A nibble appears at the outputs between 1 and 2*S reference cycles after the edge that samples its second dibit, where S is 1 at 100 Mbps and 10 at 10 Mbps.
- R12: With crs_dv_i low in idle, any value on rxd_i produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 50 MHz reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rate_10_i | input | 1 | Static rate select: 1 = 10 Mbps, 0 = 100 Mbps |
| crs_dv_i | input | 1 | Combined carrier sense and receive data valid from the PHY |
| rxd_i | input | 2 | Receive dibit from the PHY |
| rx_er_i | input | 1 | Receive error from the PHY |
| mii_rx_clk_o | output | 1 | Divided receive clock to the MAC |
| mii_rx_dv_o | output | 1 | Nibble data valid |
| mii_rxd_o | output | 4 | Receive nibble |
| mii_rx_er_o | output | 1 | Receive error for the current nibble |

## Verification
A nibble is complete at the edge that samples its second dibit. It reaches the outputs at the next rising edge of mii_rx_clk_o, which is 1 or 2 reference cycles later at 100 Mbps and 10 or 20 cycles later at 10 Mbps. The bench notes the edge index at which it presents the second preamble dibit and requires the rise of mii_rx_dv_o to fall inside that window. Nibbles are captured the way a MAC would capture them: on reference-clock falling edges at which mii_rx_clk_o has just gone low, half a receive-clock period after the outputs last moved. At 10 Mbps every unsampled cycle carries random values, so any sampling outside the tenth-cycle slot corrupts the captured stream.

// File: rtl/rmii_rx_pkg.sv
package rmii_rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SYNC,
    ST_FRAME
  } rx_state_e;

  typedef struct packed {
    logic [3:0] nib;
    logic       er;
  } nibble_t;

endpackage

// File: rtl/rx_sample_strobe.sv
module rx_sample_strobe #(
  parameter int unsigned DIV_10M = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rate_10_i,
  output logic strobe_o
);
  localparam int unsigned CW = (DIV_10M > 1) ? $clog2(DIV_10M) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_10M - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!rate_10_i)      cnt_q <= '0;
    else if (cnt_q == LAST)   cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  // first slot begins on the first edge after reset release
  assign strobe_o = !rate_10_i || (cnt_q == '0);
endmodule

// File: rtl/rx_nibble_fsm.sv
module rx_nibble_fsm
  import rmii_rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       strobe_i,
  input  logic       crs_dv_i,
  input  logic [1:0] rxd_i,
  input  logic       rx_er_i,
  output logic       nib_vld_o,
  output nibble_t    nib_o
);
  rx_state_e  state_q, state_d;
  logic       half_q, half_d;
  logic [1:0] low_q, low_d;
  logic       crs0_q, crs0_d;
  logic       er0_q, er0_d;
  logic       emit;

  always_comb begin
    state_d = state_q;
    half_d  = half_q;
    low_d   = low_q;
    crs0_d  = crs0_q;
    er0_d   = er0_q;
    emit    = 1'b0;
    if (strobe_i) begin
      unique case (state_q)
        ST_IDLE: begin
          if (crs_dv_i && rxd_i != 2'b00) begin
            low_d   = rxd_i;
            er0_d   = rx_er_i;
            state_d = ST_SYNC;
          end
        end
        ST_SYNC: begin
          if (!crs_dv_i) begin
            state_d = ST_IDLE;
          end else begin
            emit    = 1'b1;
            half_d  = 1'b0;
            state_d = ST_FRAME;
          end
        end
        ST_FRAME: begin
          if (!half_q) begin
            low_d  = rxd_i;
            crs0_d = crs_dv_i;
            er0_d  = rx_er_i;
            half_d = 1'b1;
          end else begin
            half_d = 1'b0;
            if (!crs0_q && !crs_dv_i) state_d = ST_IDLE;
            else                      emit    = 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      half_q    <= 1'b0;
      low_q     <= 2'b00;
      crs0_q    <= 1'b0;
      er0_q     <= 1'b0;
      nib_vld_o <= 1'b0;
      nib_o     <= '0;
    end else begin
      state_q   <= state_d;
      half_q    <= half_d;
      low_q     <= low_d;
      crs0_q    <= crs0_d;
      er0_q     <= er0_d;
      nib_vld_o <= emit;
      if (emit) begin
        nib_o.nib <= {rxd_i, low_q};
        nib_o.er  <= er0_q | rx_er_i;
      end
    end
  end
endmodule

// File: rtl/mii_rx_out.sv
module mii_rx_out
  import rmii_rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       strobe_i,
  input  logic       nib_vld_i,
  input  nibble_t    nib_i,
  output logic       mii_rx_clk_o,
  output logic       mii_rx_dv_o,
  output logic [3:0] mii_rxd_o,
  output logic       mii_rx_er_o
);
  logic    ph_q;
  logic    hold_v_q;
  nibble_t hold_q;
  logic    update;

  // outputs move only on the edge that drives the receive clock high
  assign update       = strobe_i && !ph_q;
  assign mii_rx_clk_o = ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q        <= 1'b0;
      hold_v_q    <= 1'b0;
      hold_q      <= '0;
      mii_rx_dv_o <= 1'b0;
      mii_rxd_o   <= 4'h0;
      mii_rx_er_o <= 1'b0;
    end else begin
      if (strobe_i) ph_q <= ~ph_q;
      if (update) begin
        if (hold_v_q) begin
          mii_rx_dv_o <= 1'b1;
          mii_rxd_o   <= hold_q.nib;
          mii_rx_er_o <= hold_q.er;
          hold_v_q    <= nib_vld_i;
          if (nib_vld_i) hold_q <= nib_i;
        end else if (nib_vld_i) begin
          mii_rx_dv_o <= 1'b1;
          mii_rxd_o   <= nib_i.nib;
          mii_rx_er_o <= nib_i.er;
        end else begin
          mii_rx_dv_o <= 1'b0;
          mii_rxd_o   <= 4'h0;
          mii_rx_er_o <= 1'b0;
        end
      end else if (nib_vld_i) begin
        hold_v_q <= 1'b1;
        hold_q   <= nib_i;
      end
    end
  end
endmodule

// File: rtl/rmii_rx_to_mii.sv
module rmii_rx_to_mii
  import rmii_rx_pkg::*;
#(
  parameter int unsigned DIV_10M = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rate_10_i,
  input  logic       crs_dv_i,
  input  logic [1:0] rxd_i,
  input  logic       rx_er_i,
  output logic       mii_rx_clk_o,
  output logic       mii_rx_dv_o,
  output logic [3:0] mii_rxd_o,
  output logic       mii_rx_er_o
);
  logic    strobe;
  logic    nib_vld;
  nibble_t nib;

  rx_sample_strobe #(.DIV_10M(DIV_10M)) u_strobe (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rate_10_i(rate_10_i),
    .strobe_o (strobe)
  );

  rx_nibble_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (strobe),
    .crs_dv_i (crs_dv_i),
    .rxd_i    (rxd_i),
    .rx_er_i  (rx_er_i),
    .nib_vld_o(nib_vld),
    .nib_o    (nib)
  );

  mii_rx_out u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .strobe_i    (strobe),
    .nib_vld_i   (nib_vld),
    .nib_i       (nib),
    .mii_rx_clk_o(mii_rx_clk_o),
    .mii_rx_dv_o (mii_rx_dv_o),
    .mii_rxd_o   (mii_rxd_o),
    .mii_rx_er_o (mii_rx_er_o)
  );
endmodule

// File: rtl/rmii_rx_to_mii_chk.sv
module rmii_rx_to_mii_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rate_10_i,
  input logic       mii_rx_clk_o,
  input logic       mii_rx_dv_o,
  input logic [3:0] mii_rxd_o,
  input logic       mii_rx_er_o
);
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mii_rx_dv_o |-> (mii_rxd_o == 4'h0) && !mii_rx_er_o); // R6

  AST_OUT_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(mii_rx_clk_o) |-> $stable(mii_rx_dv_o) && $stable(mii_rxd_o) && $stable(mii_rx_er_o)); // R7

  AST_CLK_100M: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rate_10_i |=> (mii_rx_clk_o != $past(mii_rx_clk_o))); // R7

  AST_DV_RISE_CLK_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mii_rx_dv_o) |-> mii_rx_clk_o); // R4
endmodule

bind rmii_rx_to_mii rmii_rx_to_mii_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rate_10_i   (rate_10_i),
  .mii_rx_clk_o(mii_rx_clk_o),
  .mii_rx_dv_o (mii_rx_dv_o),
  .mii_rxd_o   (mii_rxd_o),
  .mii_rx_er_o (mii_rx_er_o)
);

// File: tb/rmii_rx_to_mii_tb.sv
module rmii_rx_to_mii_tb;
  localparam int WD_LIMIT = 190000;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rate_10 = 1'b0;
  logic       crs = 1'b0;
  logic [1:0] rxd = 2'b00;
  logic       rxer = 1'b0;
  logic       mclk, dv, er;
  logic [3:0] nib;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  int slot = 1;
  bit done = 0;

  // monitor state (written only by the monitor)
  logic [3:0] got_n[$];
  logic       got_e[$];
  int  bursts = 0;
  int  rise_cyc = 0;
  int  zero_viol = 0;
  int  period_bad = 0;
  int  rises = 0;
  int  last_rise = 0;
  bit  have_rise = 0;
  logic prev_mclk = 1'b0, prev_dv = 1'b0;

  always #5 clk = ~clk;

  rmii_rx_to_mii u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .rate_10_i   (rate_10),
    .crs_dv_i    (crs),
    .rxd_i       (rxd),
    .rx_er_i     (rxer),
    .mii_rx_clk_o(mclk),
    .mii_rx_dv_o (dv),
    .mii_rxd_o   (nib),
    .mii_rx_er_o (er)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst_ni) begin
      have_rise = 0;
      rises = 0;
    end else begin
      if (!dv && (nib != 4'h0 || er)) zero_viol++;
      if (dv && !prev_dv) begin
        bursts++;
        rise_cyc = cyc;
      end
      if (prev_mclk && !mclk && dv) begin
        got_n.push_back(nib);
        got_e.push_back(er);
      end
      if (mclk && !prev_mclk) begin
        if (have_rise && (cyc - last_rise) != 2 * slot) period_bad++;
        last_rise = cyc;
        have_rise = 1;
        rises++;
      end
    end
    prev_mclk = mclk;
    prev_dv   = dv;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // caller is at a negedge; the next posedge samples the dibit
  task automatic drive(input logic c, input logic [1:0] d, input logic e);
    crs = c; rxd = d; rxer = e;
    @(negedge clk);
    for (int i = 1; i < slot; i++) begin
      crs = 1'($urandom); rxd = 2'($urandom); rxer = 1'($urandom);
      @(negedge clk);
    end
  endtask

  task automatic do_reset(input logic r10);
    rst_ni = 1'b0; rate_10 = r10; slot = r10 ? 10 : 1;
    crs = 0; rxd = 0; rxer = 0;
    repeat (4) @(negedge clk);
    check(!mclk && !dv && nib == 4'h0 && !er, "R1 reset outputs", {mclk, dv, er, nib}, 0);
    rst_ni = 1'b1;
  endtask

  task automatic idle_tail(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 2'($urandom), 1'b0);
  endtask

  task automatic send_frame(input int nlead, input int nbytes, input int ntog,
                            input int er_pos, input string tag);
    logic [3:0] en[$];
    logic       ee[$];
    int b0, k0, e_edge, mis, dly;
    logic [7:0] b;
    logic [1:0] d1, d2;
    b0 = got_n.size();
    k0 = bursts;
    for (int i = 0; i < 15; i++) begin en.push_back(4'h5); ee.push_back(1'b0); end
    en.push_back(4'hD); ee.push_back(1'b0);
    for (int i = 0; i < nlead; i++) drive(1'b1, 2'b00, 1'b0);
    drive(1'b1, 2'b01, 1'b0);
    e_edge = cyc + 1;
    drive(1'b1, 2'b01, 1'b0);
    for (int i = 0; i < 29; i++) drive(1'b1, 2'b01, 1'b0);
    drive(1'b1, 2'b11, 1'b0);
    for (int i = 0; i < nbytes; i++) begin
      b = 8'($urandom);
      en.push_back(b[3:0]); ee.push_back(1'b0);
      en.push_back(b[7:4]); ee.push_back(1'b0);
      for (int j = 0; j < 4; j++) drive(1'b1, b[2*j +: 2], (4*i + j) == er_pos);
    end
    if (er_pos >= 0) ee[16 + er_pos / 2] = 1'b1;
    for (int i = 0; i < ntog; i++) begin
      d1 = 2'($urandom); d2 = 2'($urandom);
      drive(1'b0, d1, 1'b0);
      drive(1'b1, d2, 1'b0);
      en.push_back({d2, d1}); ee.push_back(1'b0);
    end
    drive(1'b0, 2'b00, 1'b0);
    drive(1'b0, 2'b00, 1'b0);
    idle_tail(8);
    check(bursts - k0 == 1, {tag, " R4 single dv burst"}, bursts - k0, 1);
    check(got_n.size() - b0 == en.size(), {tag, " R5 nibble count"}, got_n.size() - b0, en.size());
    mis = -1;
    for (int i = 0; i < en.size() && b0 + i < got_n.size(); i++)
      if (mis < 0 && got_n[b0 + i] != en[i]) mis = i;
    check(mis < 0, {tag, " R3 nibble data"}, (mis < 0) ? 0 : int'(got_n[b0 + mis]),
          (mis < 0) ? 0 : int'(en[mis]));
    mis = -1;
    for (int i = 0; i < ee.size() && b0 + i < got_e.size(); i++)
      if (mis < 0 && got_e[b0 + i] != ee[i]) mis = i;
    check(mis < 0, {tag, " R10 error flag"}, mis, -1);
    dly = rise_cyc - e_edge;
    check(dly >= 1 && dly <= 2 * slot, {tag, " R11 latency"}, dly, 2 * slot);
  endtask

  task automatic no_frame(input string tag, input int k0);
    check(bursts == k0, tag, bursts - k0, 0);
  endtask

  task automatic negative_cases();
    int k0;
    k0 = bursts;
    drive(1'b1, 2'b00, 1'b0); drive(1'b1, 2'b00, 1'b0);
    drive(1'b1, 2'b01, 1'b0); drive(1'b0, 2'b01, 1'b0);
    idle_tail(6);
    no_frame("R9 mid-nibble drop before alignment", k0);
    k0 = bursts;
    for (int i = 0; i < 10; i++) drive(1'b0, 2'($urandom), 1'($urandom));
    idle_tail(4);
    no_frame("R12 data with carrier low", k0);
    k0 = bursts;
    for (int i = 0; i < 6; i++) drive(1'b1, 2'b00, 1'b0);
    idle_tail(6);
    no_frame("R2 zero dibits alone", k0);
  endtask

  always @(posedge clk) begin
    if (cyc == WD_LIMIT && !done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, WD_LIMIT);
      $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0017));
    @(negedge clk);
    // 100 Mbps
    do_reset(1'b0);
    negative_cases();
    send_frame(0, 64, 0, -1, "dir100");
    send_frame(3, 70, 2, 5, "tog100");
    for (int f = 0; f < 4; f++)
      send_frame(int'($urandom % 6), 64 + int'($urandom % 33), int'($urandom % 4),
                 ($urandom % 2) ? int'($urandom % 256) : -1, "rnd100");
    check(period_bad == 0 && rises > 10, "R7 clock period 100M", period_bad, 0);
    // 10 Mbps, unsampled cycles carry random values (R8)
    do_reset(1'b1);
    negative_cases();
    send_frame(2, 64, 1, 9, "R8 dir10");
    send_frame(int'($urandom % 6), 64, 3, -1, "R8 rnd10");
    check(period_bad == 0 && rises > 10, "R7 clock period 10M", period_bad, 0);
    check(zero_viol == 0, "R6 idle outputs zero", zero_viol, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule